// File: doc/BRIEF.md
# Command Word Initialization Sequencer

This block sits behind a host write port with an active-low chip select, an active-low write strobe and a single address bit. It interprets each accepted write as one of several command types. A write with the address bit low and data bit 4 set always opens a new setup sequence. The sequence then takes one, two or three more words on address-high writes, depending on two flags carried in the opening word. Once the sequence is complete, address-high writes load an interrupt mask. Address-low writes with bit 4 clear carry run-time commands.

All decoded configuration is held in registers and presented as plain output fields: the trigger mode, whether the block is standalone or cascaded, the vector spacing, the vector base byte, the cascade word, the mode word and the mask. Run-time commands appear as one-cycle strobes. An end-of-interrupt strobe comes from the first command type. A read-select strobe with a latched two-bit selector comes from the second. Logic that acts on these outputs sits elsewhere.

Top module: `cmdw_init_seq`

## Requirements
- R1: An accepted write with `addr`=0 and `wdata[4]`=1 opens a new sequence from any state: `ready` drops to 0 and `irq_mask` clears to 0 at the next clock.
- R2: The first address-high write after the opening word is stored whole in `vec_base`.
- R3: The cascade word is expected next only when bit 1 of the opening word is 0. The next address-high write is stored in `casc_word`. When bit 1 is 1 this step is skipped.
- R4: The mode word is expected only when bit 0 of the opening word is 1. Its bits [4:0] are stored in `mode_word`. When bit 0 is 0, `mode_word` is cleared to 0 by the opening word and the step is skipped.
- R5: From the opening word, bit 3 drives `trig_level` (1 = level-sensitive), bit 2 drives `intv4` (1 = spacing of 4, 0 = spacing of 8), and bit 1 drives `single_mode`.
- R6: `ready` rises only on the clock that accepts the last word the sequence needs.
- R7: When `ready` is 1, an address-high write loads `irq_mask` with `wdata`. While `ready` is 0, `irq_mask` stays 0.
- R8: A write is accepted on the first rising edge at which `cs_n` and `wr_n` are both 0. It is acted on once however long both stay low. No further write is accepted until `wr_n` has returned high. A write with `cs_n`=1 has no effect.
- R9: When `ready` is 1, an address-low write with `wdata[4:3]`=00 and `wdata[5]`=1 raises `eoi_pulse` for exactly one cycle. With `wdata[5]`=0 no pulse is raised.
- R10: When `ready` is 1, an address-low write with `wdata[4:3]`=01 latches `wdata[1:0]` into `rdsel` and raises `rdsel_pulse` for one cycle.
- R11: Synchronous reset `rst` clears every output to 0 and leaves the block waiting for an opening word.
- R12: During a sequence, an address-low write with `wdata[4]`=0 is ignored: the step and every stored field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Register select bit |
| wdata | input | 8 | Write data |
| ready | output | 1 | Setup sequence complete |
| trig_level | output | 1 | Level-sensitive request inputs |
| intv4 | output | 1 | Vector spacing of 4 (else 8) |
| single_mode | output | 1 | Standalone, no cascade |
| vec_base | output | 8 | Vector base byte |
| casc_word | output | 8 | Cascade configuration word |
| mode_word | output | 5 | Mode word bits |
| irq_mask | output | 8 | Interrupt mask |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| rdsel_pulse | output | 1 | One-cycle read-select strobe |
| rdsel | output | 2 | Latched read-register selector |

## Verification
The stimulus table walks the four sequence lengths: both optional steps, neither, only the cascade word, and only the mode word. Each is followed by a mask write, so an error in step skipping shows up as an address-high word landing in the wrong field or as `ready` rising a word early or late. One row sends a run-time command in the middle of a sequence to show it is ignored. Directed cases then hold the write strobe low for several cycles to tell single acceptance from repeated acceptance. They drive a write with chip select high, compare end-of-interrupt commands with and without bit 5, check the read-select latch, and reset in the middle of operation.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;

  // bit positions inside command bytes
  localparam int unsigned B_IC4  = 0;  // opening word: mode word follows
  localparam int unsigned B_SNGL = 1;  // opening word: standalone
  localparam int unsigned B_ADI  = 2;  // opening word: spacing of 4
  localparam int unsigned B_LTIM = 3;  // opening word: level trigger
  localparam int unsigned B_INIT = 4;  // address-low: opening word marker
  localparam int unsigned B_OW3  = 3;  // address-low: read-select command
  localparam int unsigned B_EOI  = 5;  // end-of-interrupt request

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic init;
    logic ow2;
    logic ow3;
    logic hi;
  } wr_kind_t;

endpackage

// File: rtl/cmdw_wr_detect.sv
module cmdw_wr_detect
  import cmdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       addr,
  input  logic [1:0] sel_bits,   // {bit4, bit3} of the write data
  output logic       wr_stb,
  output wr_kind_t   kind
);

  logic armed;

  // one acceptance per low period of wr_n
  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b1;
    else if (wr_n)      armed <= 1'b1;
    else if (!cs_n)     armed <= 1'b0;
  end

  assign wr_stb = !cs_n && !wr_n && armed;

  always_comb begin
    kind.hi   = addr;
    kind.init = !addr &&  sel_bits[1];
    kind.ow2  = !addr && !sel_bits[1] && !sel_bits[0];
    kind.ow3  = !addr && !sel_bits[1] &&  sel_bits[0];
  end

endmodule

// File: rtl/cmdw_seq_fsm.sv
module cmdw_seq_fsm
  import cmdw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_stb,
  input  wr_kind_t kind,
  input  logic     cfg_single,
  input  logic     cfg_ic4,
  output logic     ld_w1,
  output logic     ld_w2,
  output logic     ld_w3,
  output logic     ld_w4,
  output logic     ld_mask,
  output logic     ld_ow2,
  output logic     ld_ow3,
  output logic     ready
);

  seq_state_t st, nxt;

  always_comb begin
    nxt     = st;
    ld_w1   = 1'b0;
    ld_w2   = 1'b0;
    ld_w3   = 1'b0;
    ld_w4   = 1'b0;
    ld_mask = 1'b0;
    ld_ow2  = 1'b0;
    ld_ow3  = 1'b0;
    if (wr_stb) begin
      if (kind.init) begin
        ld_w1 = 1'b1;
        nxt   = ST_W2;
      end else begin
        unique case (st)
          ST_W2: if (kind.hi) begin
            ld_w2 = 1'b1;
            if (!cfg_single)  nxt = ST_W3;
            else if (cfg_ic4) nxt = ST_W4;
            else              nxt = ST_RUN;
          end
          ST_W3: if (kind.hi) begin
            ld_w3 = 1'b1;
            nxt   = cfg_ic4 ? ST_W4 : ST_RUN;
          end
          ST_W4: if (kind.hi) begin
            ld_w4 = 1'b1;
            nxt   = ST_RUN;
          end
          ST_RUN: begin
            ld_mask = kind.hi;
            ld_ow2  = kind.ow2;
            ld_ow3  = kind.ow3;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ready <= 1'b0;
    end else begin
      st    <= nxt;
      ready <= (nxt == ST_RUN);
    end
  end

endmodule

// File: rtl/cmdw_cfg_regs.sv
module cmdw_cfg_regs
  import cmdw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 5,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ld_w1,
  input  logic              ld_w2,
  input  logic              ld_w3,
  input  logic              ld_w4,
  input  logic              ld_mask,
  input  logic              ld_ow2,
  input  logic              ld_ow3,
  output logic              cfg_ic4,
  output logic              cfg_single,
  output logic              cfg_adi,
  output logic              cfg_ltim,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] casc_word,
  output logic [MODE_W-1:0] mode_word,
  output logic [DATA_W-1:0] irq_mask,
  output logic              eoi_pulse,
  output logic              rdsel_pulse,
  output logic [RSEL_W-1:0] rdsel
);

  // opening-word flags
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ic4    <= 1'b0;
      cfg_single <= 1'b0;
      cfg_adi    <= 1'b0;
      cfg_ltim   <= 1'b0;
    end else if (ld_w1) begin
      cfg_ic4    <= wdata[B_IC4];
      cfg_single <= wdata[B_SNGL];
      cfg_adi    <= wdata[B_ADI];
      cfg_ltim   <= wdata[B_LTIM];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        vec_base <= '0;
    else if (ld_w2) vec_base <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        casc_word <= '0;
    else if (ld_w3) casc_word <= wdata;
  end

  // mode word cleared when the opening word omits it
  always_ff @(posedge clk) begin
    if (rst)                          mode_word <= '0;
    else if (ld_w1 && !wdata[B_IC4])  mode_word <= '0;
    else if (ld_w4)                   mode_word <= wdata[MODE_W-1:0];
  end

  // mask: one flop per line
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || ld_w1) irq_mask[i] <= 1'b0;
      else if (ld_mask) irq_mask[i] <= wdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_pulse   <= 1'b0;
      rdsel_pulse <= 1'b0;
      rdsel       <= '0;
    end else begin
      eoi_pulse   <= ld_ow2 && wdata[B_EOI];
      rdsel_pulse <= ld_ow3;
      if (ld_ow3) rdsel <= wdata[RSEL_W-1:0];
    end
  end

endmodule

// File: rtl/cmdw_init_seq.sv
module cmdw_init_seq
  import cmdw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 5,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              trig_level,
  output logic              intv4,
  output logic              single_mode,
  output logic [DATA_W-1:0] vec_base,
  output logic [DATA_W-1:0] casc_word,
  output logic [MODE_W-1:0] mode_word,
  output logic [DATA_W-1:0] irq_mask,
  output logic              eoi_pulse,
  output logic              rdsel_pulse,
  output logic [RSEL_W-1:0] rdsel
);

  logic     wr_stb;
  wr_kind_t kind;
  logic     cfg_ic4;
  logic     ld_w1, ld_w2, ld_w3, ld_w4, ld_mask, ld_ow2, ld_ow3;

  cmdw_wr_detect u_det (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .sel_bits ({wdata[B_INIT], wdata[B_OW3]}),
    .wr_stb   (wr_stb),
    .kind     (kind)
  );

  cmdw_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .kind       (kind),
    .cfg_single (single_mode),
    .cfg_ic4    (cfg_ic4),
    .ld_w1      (ld_w1),
    .ld_w2      (ld_w2),
    .ld_w3      (ld_w3),
    .ld_w4      (ld_w4),
    .ld_mask    (ld_mask),
    .ld_ow2     (ld_ow2),
    .ld_ow3     (ld_ow3),
    .ready      (ready)
  );

  cmdw_cfg_regs #(
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .RSEL_W (RSEL_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wdata       (wdata),
    .ld_w1       (ld_w1),
    .ld_w2       (ld_w2),
    .ld_w3       (ld_w3),
    .ld_w4       (ld_w4),
    .ld_mask     (ld_mask),
    .ld_ow2      (ld_ow2),
    .ld_ow3      (ld_ow3),
    .cfg_ic4     (cfg_ic4),
    .cfg_single  (single_mode),
    .cfg_adi     (intv4),
    .cfg_ltim    (trig_level),
    .vec_base    (vec_base),
    .casc_word   (casc_word),
    .mode_word   (mode_word),
    .irq_mask    (irq_mask),
    .eoi_pulse   (eoi_pulse),
    .rdsel_pulse (rdsel_pulse),
    .rdsel       (rdsel)
  );

endmodule

// File: rtl/cmdw_init_seq_chk.sv
module cmdw_init_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_stb,
  input logic              ready,
  input logic [DATA_W-1:0] irq_mask,
  input logic              eoi_pulse,
  input logic              rdsel_pulse
);

  p_init_drops_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !addr && wdata[cmdw_pkg::B_INIT]) |=> (!ready && irq_mask == '0));

  p_ready_after_hi_write_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(wr_stb) && $past(addr)));

  p_mask_zero_unready_r7: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (irq_mask == '0));

  p_one_accept_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_eoi_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    eoi_pulse |=> !eoi_pulse);

  p_eoi_from_write_r9: assert property (@(posedge clk) disable iff (rst)
    eoi_pulse |-> ($past(wr_stb) && !$past(addr)));

  p_rdsel_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    rdsel_pulse |=> !rdsel_pulse);

endmodule

bind cmdw_init_seq cmdw_init_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .wdata       (wdata),
  .wr_stb      (wr_stb),
  .ready       (ready),
  .irq_mask    (irq_mask),
  .eoi_pulse   (eoi_pulse),
  .rdsel_pulse (rdsel_pulse)
);

// File: tb/tb_cmdw_init_seq.sv
`timescale 1ns/1ps
module tb_cmdw_init_seq;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n, wr_n, addr;
  logic [7:0] wdata;
  logic       ready, trig_level, intv4, single_mode;
  logic [7:0] vec_base, casc_word, irq_mask;
  logic [4:0] mode_word;
  logic       eoi_pulse, rdsel_pulse;
  logic [1:0] rdsel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cmdw_init_seq dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .ready(ready), .trig_level(trig_level), .intv4(intv4), .single_mode(single_mode),
    .vec_base(vec_base), .casc_word(casc_word), .mode_word(mode_word),
    .irq_mask(irq_mask), .eoi_pulse(eoi_pulse), .rdsel_pulse(rdsel_pulse), .rdsel(rdsel)
  );

  typedef struct packed {
    logic       a;
    logic [7:0] d;
    logic       rdy;
    logic [7:0] mask;
    logic [7:0] vec;
    logic [4:0] mode;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 16;
  // sequences: full w/o cascade, minimal, cascade w/o mode, full with stray command
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 8'h13, 1'b0, 8'h00, 8'h00, 5'h00, 4'd1},  // R1 open, mode word needed
    '{1'b1, 8'h20, 1'b0, 8'h00, 8'h20, 5'h00, 4'd2},  // R2 vector base
    '{1'b1, 8'h03, 1'b1, 8'h00, 8'h20, 5'h03, 4'd4},  // R4 mode word, R3 skipped
    '{1'b1, 8'hA5, 1'b1, 8'hA5, 8'h20, 5'h03, 4'd7},  // R7 mask
    '{1'b0, 8'h1A, 1'b0, 8'h00, 8'h20, 5'h00, 4'd4},  // R4 clear of mode word
    '{1'b1, 8'h48, 1'b1, 8'h00, 8'h48, 5'h00, 4'd6},  // R6 two-word sequence
    '{1'b1, 8'h0F, 1'b1, 8'h0F, 8'h48, 5'h00, 4'd7},
    '{1'b0, 8'h10, 1'b0, 8'h00, 8'h48, 5'h00, 4'd1},
    '{1'b1, 8'h60, 1'b0, 8'h00, 8'h60, 5'h00, 4'd3},  // R3 cascade word pending
    '{1'b1, 8'h04, 1'b1, 8'h00, 8'h60, 5'h00, 4'd3},
    '{1'b1, 8'hF0, 1'b1, 8'hF0, 8'h60, 5'h00, 4'd7},
    '{1'b0, 8'h11, 1'b0, 8'h00, 8'h60, 5'h00, 4'd1},
    '{1'b1, 8'h70, 1'b0, 8'h00, 8'h70, 5'h00, 4'd2},
    '{1'b0, 8'h20, 1'b0, 8'h00, 8'h70, 5'h00, 4'd12}, // R12 stray command ignored
    '{1'b1, 8'h02, 1'b0, 8'h00, 8'h70, 5'h00, 4'd3},
    '{1'b1, 8'h1F, 1'b1, 8'h00, 8'h70, 5'h1F, 4'd6}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1; addr = 1'b0; wdata = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 ready", int'(ready), 0);
    check("R11 mask", int'(irq_mask), 0);
    check("R11 fields", int'({vec_base, casc_word, mode_word, trig_level, intv4, single_mode}), 0);
    check("R11 strobes", int'({eoi_pulse, rdsel_pulse, rdsel}), 0);

    for (int i = 0; i < NROWS; i++) begin
      wr(TBL[i].a, TBL[i].d);
      check($sformatf("R%0d row %0d ready", TBL[i].req, i), int'(ready), int'(TBL[i].rdy));
      check($sformatf("R%0d row %0d mask", TBL[i].req, i), int'(irq_mask), int'(TBL[i].mask));
      check($sformatf("R%0d row %0d vec", TBL[i].req, i), int'(vec_base), int'(TBL[i].vec));
      check($sformatf("R%0d row %0d mode", TBL[i].req, i), int'(mode_word), int'(TBL[i].mode));
    end
    check("R3 cascade word", int'(casc_word), 8'h02);

    // R5 field decode: level, spacing 4, standalone, no mode word
    wr(1'b0, 8'h1E);
    check("R5 trig_level", int'(trig_level), 1);
    check("R5 intv4", int'(intv4), 1);
    check("R5 single_mode", int'(single_mode), 1);
    check("R6 not ready yet", int'(ready), 0);
    wr(1'b1, 8'h33);
    check("R6 ready after vector", int'(ready), 1);
    check("R3 cascade word kept", int'(casc_word), 8'h02);

    // R8 write with chip select high is ignored
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 1'b1; wdata = 8'h55;
    @(negedge clk);
    wr_n = 1'b1;
    check("R8 cs high ignored", int'(irq_mask), 0);
    wr(1'b1, 8'hC3);
    check("R7 mask load", int'(irq_mask), 8'hC3);

    // R9 end-of-interrupt
    wr(1'b0, 8'h20);
    check("R9 eoi high", int'(eoi_pulse), 1);
    @(negedge clk);
    check("R9 eoi one cycle", int'(eoi_pulse), 0);
    wr(1'b0, 8'h00);
    check("R9 no eoi without bit5", int'(eoi_pulse), 0);

    // R8 held-low write acted on once
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 1'b0; wdata = 8'h20;
    @(negedge clk);
    check("R8 held first", int'(eoi_pulse), 1);
    @(negedge clk);
    check("R8 held second", int'(eoi_pulse), 0);
    @(negedge clk);
    check("R8 held third", int'(eoi_pulse), 0);
    cs_n = 1'b1; wr_n = 1'b1;

    // R10 read select
    wr(1'b0, 8'h0A);
    check("R10 rdsel", int'(rdsel), 2);
    check("R10 rdsel_pulse", int'(rdsel_pulse), 1);
    @(negedge clk);
    check("R10 pulse one cycle", int'(rdsel_pulse), 0);
    check("R10 rdsel held", int'(rdsel), 2);
    check("R7 mask unaffected", int'(irq_mask), 8'hC3);

    // R11 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 ready after reset", int'(ready), 0);
    check("R11 mask after reset", int'(irq_mask), 0);
    check("R11 vec after reset", int'(vec_base), 0);
    check("R11 rdsel after reset", int'(rdsel), 0);
    wr(1'b1, 8'h77);
    check("R11 idle ignores hi write", int'({ready, vec_base}), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule